// File: doc/BRIEF.md
# Public Test Data Registers: Bypass, Identification, Signature and Self-Test Status

This block holds the serial test data registers that a boundary-scan TAP controller selects for its public non-boundary instructions. It holds four registers. The first is a one-stage bypass register. The second is a 32-bit identification register that captures a fixed device code. The third is a 32-bit self-test signature register, and the fourth is a one-stage self-test completion status. The controller supplies a one-hot select vector, the capture, shift and update strobes of the data-register path, and the serial input. The block returns the serial output of whichever register is selected.

All four registers are read-only. Capture loads each register from its own source: a constant, a parallel input, or the status input. Shift moves the selected register one position toward the serial output, least significant bit first. Update never changes anything. A register that is not selected keeps its contents.

Top module: `tdr_public_regs`

## Requirements
- R1: While reset is active, and until the first capture or shift after it, every register stage is 0, so `tdo` is 0 for every select value.
- R2: `dr_sel` is one-hot, with bit 0 for bypass, bit 1 for identification, bit 2 for signature and bit 3 for self-test status. When `dr_sel` is 0, `tdo` is 0 whatever the strobes and `tdi` do.
- R3: With bypass selected, capture loads 0. Each shift places `tdi` on `tdo` from the next clock edge onward, so the data is delayed by one cycle.
- R4: With identification selected, capture loads 0x0000402F. Bit 0 is 1, bits 11:1 hold manufacturer code 0x017, bits 27:12 hold part number 0x0004 and bits 31:28 hold version 0.
- R5: A 32-bit register shifts out bit 0 first and takes `tdi` into bit 31. Exactly 32 shifts move its whole contents out, and after those 32 shifts it holds the 32 `tdi` bits in arrival order.
- R6: With signature selected, capture loads `sig_in`, which then shifts out under R5.
- R7: With self-test status selected, capture loads `bist_done`. The status register is one stage, so a shift places `tdi` on `tdo` after one cycle.
- R8: Update has no effect on any register. `tdo` and all contents read out later are the same as if the update had not occurred.
- R9: A register that is not selected keeps its contents through capture and shift cycles of other registers.
- R10: When capture and shift occur in the same cycle, capture wins. When update occurs in the same cycle as capture or shift, neither of them takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dr_sel | input | 4 | One-hot register select |
| capture_dr | input | 1 | Capture strobe |
| shift_dr | input | 1 | Shift strobe |
| update_dr | input | 1 | Update strobe (no register reacts to it) |
| tdi | input | 1 | Serial data in |
| sig_in | input | 32 | Self-test signature, parallel |
| bist_done | input | 1 | Self-test completion flag |
| tdo | output | 1 | Serial data out of the selected register |

## Verification
Two operations can fall in the same cycle: capture with shift, and update with either of them. The bench provokes both. To test capture with shift, it strobes capture and shift together on the signature register, so only the captured word can come out. To test update with capture or shift, it puts update alongside a capture while `sig_in` has already changed, and alongside shifts of the identification word. It then reads the full register out and compares it with the word that would be present if the suppressed operation had never happened.

// File: rtl/tdr_pkg.sv
package tdr_pkg;
  localparam int SEL_W   = 4;
  localparam int SEL_BYP = 0;
  localparam int SEL_IDN = 1;
  localparam int SEL_SIG = 2;
  localparam int SEL_BST = 3;
  typedef logic [SEL_W-1:0] sel_t;
endpackage

// File: rtl/tdr_rst_sync.sv
module tdr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= 2'b00;
    else        stg_q <= {stg_q[0], 1'b1};
  end

  assign rst_q = stg_q[1];
endmodule

// File: rtl/tdr_ring.sv
module tdr_ring #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_en,
  input  logic         shift_en,
  input  logic [W-1:0] cap_val,
  input  logic         ser_in,
  output logic         ser_out
);
  logic [W-1:0] ring_q, ring_d, shifted;

  generate
    if (W == 1) begin : g_one
      assign shifted = ser_in;
    end else begin : g_many
      assign shifted = {ser_in, ring_q[W-1:1]};
    end
  endgenerate

  always_comb begin
    ring_d = ring_q;
    if (cap_en)        ring_d = cap_val;
    else if (shift_en) ring_d = shifted;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 ring_q <= '0;
    else if (cap_en || shift_en) ring_q <= ring_d;
  end

  assign ser_out = ring_q[0];
endmodule

// File: rtl/tdr_out_sel.sv
module tdr_out_sel #(
  parameter int N = 4
) (
  input  logic [N-1:0] sel,
  input  logic [N-1:0] ser,
  output logic         so
);
  always_comb begin
    so = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (sel[i]) so = ser[i];
    end
  end
endmodule

// File: rtl/tdr_public_regs.sv
module tdr_public_regs
  import tdr_pkg::*;
#(
  parameter int          SIG_W   = 32,
  parameter logic [3:0]  ID_VER  = 4'h0,
  parameter logic [15:0] ID_PART = 16'h0004,
  parameter logic [10:0] ID_MFR  = 11'h017
) (
  input  logic             tck,
  input  logic             rst_n,
  input  logic [3:0]       dr_sel,
  input  logic             capture_dr,
  input  logic             shift_dr,
  input  logic             update_dr,
  input  logic             tdi,
  input  logic [SIG_W-1:0] sig_in,
  input  logic             bist_done,
  output logic             tdo
);
  localparam int          ID_W    = 32;
  localparam logic [31:0] ID_WORD = {ID_VER, ID_PART, ID_MFR, 1'b1};

  logic             rst_sync_n;
  logic             op_cap, op_shift;
  logic [SEL_W-1:0] cap_v, shf_v, ser_v;

  tdr_rst_sync u_rst (.clk(tck), .rst_n(rst_n), .rst_q(rst_sync_n));

  // one operation per cycle: update blocks both, capture beats shift
  assign op_cap   = capture_dr && !update_dr;
  assign op_shift = shift_dr && !capture_dr && !update_dr;

  generate
    for (genvar g = 0; g < SEL_W; g++) begin : g_en
      assign cap_v[g] = op_cap   && dr_sel[g];
      assign shf_v[g] = op_shift && dr_sel[g];
    end
  endgenerate

  tdr_ring #(.W(1)) u_byp (
    .clk(tck), .rst_n(rst_sync_n), .cap_en(cap_v[SEL_BYP]), .shift_en(shf_v[SEL_BYP]),
    .cap_val(1'b0), .ser_in(tdi), .ser_out(ser_v[SEL_BYP]));

  tdr_ring #(.W(ID_W)) u_idn (
    .clk(tck), .rst_n(rst_sync_n), .cap_en(cap_v[SEL_IDN]), .shift_en(shf_v[SEL_IDN]),
    .cap_val(ID_WORD), .ser_in(tdi), .ser_out(ser_v[SEL_IDN]));

  tdr_ring #(.W(SIG_W)) u_sig (
    .clk(tck), .rst_n(rst_sync_n), .cap_en(cap_v[SEL_SIG]), .shift_en(shf_v[SEL_SIG]),
    .cap_val(sig_in), .ser_in(tdi), .ser_out(ser_v[SEL_SIG]));

  tdr_ring #(.W(1)) u_bst (
    .clk(tck), .rst_n(rst_sync_n), .cap_en(cap_v[SEL_BST]), .shift_en(shf_v[SEL_BST]),
    .cap_val(bist_done), .ser_in(tdi), .ser_out(ser_v[SEL_BST]));

  tdr_out_sel #(.N(SEL_W)) u_mux (.sel(dr_sel), .ser(ser_v), .so(tdo));
endmodule

// File: rtl/tdr_public_chk.sv
module tdr_public_chk #(
  parameter int SIG_W = 32
) (
  input logic             clk,
  input logic             rst_q,
  input logic [3:0]       dr_sel,
  input logic             capture_dr,
  input logic             shift_dr,
  input logic             update_dr,
  input logic             tdi,
  input logic [SIG_W-1:0] sig_in,
  input logic             bist_done,
  input logic             tdo
);
  // R2
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_q) $onehot0(dr_sel));
  // R2
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_q) (dr_sel == 4'b0000) |-> !tdo);
  // R3
  byp_cap_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (capture_dr && !update_dr && dr_sel == 4'b0001) |=> (dr_sel != 4'b0001) || !tdo);
  // R3
  byp_shift_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (shift_dr && !capture_dr && !update_dr && dr_sel == 4'b0001)
    |=> (dr_sel != 4'b0001) || (tdo == $past(tdi)));
  // R4
  idn_cap_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (capture_dr && !update_dr && dr_sel == 4'b0010) |=> (dr_sel != 4'b0010) || tdo);
  // R6
  sig_cap_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (capture_dr && !update_dr && dr_sel == 4'b0100)
    |=> (dr_sel != 4'b0100) || (tdo == $past(sig_in[0])));
  // R7
  bst_cap_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (capture_dr && !update_dr && dr_sel == 4'b1000)
    |=> (dr_sel != 4'b1000) || (tdo == $past(bist_done)));
  // R8
  upd_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    update_dr |=> (dr_sel != $past(dr_sel)) || $stable(tdo));
endmodule

bind tdr_public_regs tdr_public_chk #(.SIG_W(SIG_W)) u_chk (
  .clk(tck), .rst_q(rst_sync_n), .dr_sel(dr_sel), .capture_dr(capture_dr),
  .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi), .sig_in(sig_in),
  .bist_done(bist_done), .tdo(tdo));

// File: tb/test_tdr_public_regs.sv
module test_tdr_public_regs;
  logic        tck = 1'b0;
  logic        rst_n;
  logic [3:0]  dr_sel;
  logic        capture_dr, shift_dr, update_dr, tdi;
  logic [31:0] sig_in;
  logic        bist_done;
  logic        tdo;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  localparam logic [3:0] S_BYP = 4'b0001, S_IDN = 4'b0010, S_SIG = 4'b0100, S_BST = 4'b1000;
  localparam logic [31:0] ID_EXP = {4'h0, 16'h0004, 11'h017, 1'b1};

  always #10 tck = ~tck;

  tdr_public_regs i_tdr_public_regs (
    .tck(tck), .rst_n(rst_n), .dr_sel(dr_sel), .capture_dr(capture_dr),
    .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi), .sig_in(sig_in),
    .bist_done(bist_done), .tdo(tdo));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock with the given strobes; inputs change 1 ns after the edge
  task automatic step(input logic c, input logic s, input logic u, input logic d);
    capture_dr = c; shift_dr = s; update_dr = u; tdi = d;
    @(posedge tck); #1;
    capture_dr = 1'b0; shift_dr = 1'b0; update_dr = 1'b0;
  endtask

  task automatic read_word(input logic [31:0] pat, output logic [31:0] got);
    for (int i = 0; i < 32; i++) begin
      got[i] = tdo;
      step(1'b0, 1'b1, 1'b0, pat[i]);
    end
  endtask

  initial begin
    repeat (3000) @(posedge tck);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] w, pat;
    rst_n = 1'b0; dr_sel = 4'b0; capture_dr = 0; shift_dr = 0; update_dr = 0;
    tdi = 0; sig_in = 32'h0; bist_done = 1'b0;
    repeat (3) @(posedge tck); #1;
    for (int k = 0; k < 4; k++) begin
      dr_sel = 4'b1 << k; #1;
      check("R1 reset tdo", {31'b0, tdo}, 32'h0);
    end
    rst_n = 1'b1;
    repeat (3) @(posedge tck); #1;
    dr_sel = S_SIG; #1;
    check("R1 after release", {31'b0, tdo}, 32'h0);

    // R2 nothing selected
    dr_sel = 4'b0;
    for (int i = 0; i < 8; i++) begin
      step(i[0], i[1], i[2], 1'b1);
      check("R2 idle tdo", {31'b0, tdo}, 32'h0);
    end

    // R3 bypass
    dr_sel = S_BYP;
    step(1'b0, 1'b1, 1'b0, 1'b1);
    step(1'b1, 1'b0, 1'b0, 1'b1);
    check("R3 bypass capture", {31'b0, tdo}, 32'h0);
    pat = 32'hB4C3_96E1;
    for (int i = 0; i < 20; i++) begin
      step(1'b0, 1'b1, 1'b0, pat[i]);
      check("R3 bypass delay", {31'b0, tdo}, {31'b0, pat[i]});
    end

    // R4 / R5 identification
    dr_sel = S_IDN;
    step(1'b1, 1'b0, 1'b0, 1'b0);
    pat = 32'h1234_5678;
    read_word(pat, w);
    check("R4 id word", w, 32'h0000_402F);
    check("R4 id mfr", {21'b0, w[11:1]}, 32'h017);
    check("R4 id part", {16'b0, w[27:12]}, 32'h0004);
    check("R4 id bit0", {31'b0, w[0]}, 32'h1);
    read_word(32'h0, w);
    check("R5 tdi order", w, pat);

    // R6 signature sweep: walking ones plus patterns
    dr_sel = S_SIG;
    for (int k = 0; k < 36; k++) begin
      case (k)
        32: sig_in = 32'h0;
        33: sig_in = 32'hFFFF_FFFF;
        34: sig_in = 32'hA5A5_5A5A;
        35: sig_in = 32'h8000_0001;
        default: sig_in = 32'h1 << k;
      endcase
      step(1'b1, 1'b0, 1'b0, 1'b0);
      read_word(~sig_in, w);
      check("R6 signature", w, sig_in);
    end
    read_word(32'h0, w);
    check("R5 sig tdi order", w, ~sig_in);

    // R7 self-test status
    dr_sel = S_BST;
    for (int k = 0; k < 2; k++) begin
      bist_done = k[0];
      step(1'b1, 1'b0, 1'b0, ~k[0]);
      check("R7 status capture", {31'b0, tdo}, {31'b0, k[0]});
      step(1'b0, 1'b1, 1'b0, ~k[0]);
      check("R7 status shift", {31'b0, tdo}, {31'b0, ~k[0]});
    end

    // R8 update mid-shift leaves the identification readout intact
    dr_sel = S_IDN;
    step(1'b1, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 5; i++) begin
      w[i] = tdo;
      step(1'b0, 1'b1, 1'b0, 1'b1);
    end
    step(1'b0, 1'b0, 1'b1, 1'b0);
    check("R8 update tdo", {31'b0, tdo}, {31'b0, ID_EXP[5]});
    for (int i = 5; i < 32; i++) begin
      w[i] = tdo;
      step(1'b0, 1'b1, 1'b0, 1'b0);
    end
    check("R8 update no effect", w, ID_EXP);

    // R9 unselected signature holds while identification works
    dr_sel = S_SIG; sig_in = 32'hC0DE_F00D;
    step(1'b1, 1'b0, 1'b0, 1'b0);
    sig_in = 32'h0;
    dr_sel = S_IDN;
    step(1'b1, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 10; i++) step(1'b0, 1'b1, 1'b0, 1'b1);
    dr_sel = S_SIG;
    read_word(32'h0, w);
    check("R9 hold unselected", w, 32'hC0DE_F00D);

    // R10 capture beats shift
    sig_in = 32'h0F0F_3C3C;
    step(1'b1, 1'b1, 1'b0, 1'b1);
    read_word(32'h0, w);
    check("R10 capture over shift", w, 32'h0F0F_3C3C);
    // R10 update blocks capture
    sig_in = 32'h5555_AAAA;
    step(1'b1, 1'b0, 1'b0, 1'b0);
    sig_in = 32'h1111_2222;
    step(1'b1, 1'b0, 1'b1, 1'b0);
    read_word(32'h0, w);
    check("R10 update blocks capture", w, 32'h5555_AAAA);
    // R10 update blocks shift
    dr_sel = S_IDN;
    step(1'b1, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b1, 1'b1);
    read_word(32'h0, w);
    check("R10 update blocks shift", w, ID_EXP);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule